// File: doc/BRIEF.md
# Module-Stop Clock Gating Controller

This block holds an 8-bit stop register that decides which of four on-chip modules get a clock. The modules are a break unit, a floating-point unit, a debug interface unit and a trace unit. Each stop bit is turned into a clock enable, and each enable is passed through a latch-based gate that gives a glitch-free gated clock for its module. Software reaches the register through a 16-bit write port. A write is accepted only when a fixed key value sits in the upper byte, so that a stray store cannot stop a module's clock.

Two bits do not behave like plain storage. The floating-point stop bit can be set but not cleared: once that unit is stopped, only a power-on reset brings its clock back. The trace unit is interlocked with its software reset, which this block receives as an input. After its stop bit is cleared, the trace clock stays off until that reset has been seen asserted. Power-on reset is the synchronous active-low `rst_n`.

Top module: `modstop_ctrl`

## Requirements
- R1: A power-on reset (rst_n low at a rising edge) sets the register to 0x01. Only the break unit is stopped after reset, so clk_en reads 4'b1110.
- R2: rd_data[7:4] always read 0, whatever value is written to wr_data[7:4].
- R3: A write whose wr_data[15:8] is not 0x5A changes nothing.
- R4: A keyed write (wr_en high, wr_data[15:8] = 0x5A) loads bits 3, 2 and 0 of the register from wr_data[3], wr_data[2] and wr_data[0].
- R5: Bit 1 (floating-point stop) is set by a keyed write with wr_data[1] = 1. A keyed write of 0 leaves it at 1, and only R1's reset clears it.
- R6: Stop bit i set forces clk_en[i] = 0 and holds gclk[i] low. Bit 0 is the break unit, bit 1 the floating-point unit, bit 2 the debug interface unit and bit 3 the trace unit. A clear bit lets gclk[i] follow clk.
- R7: Once bit 3 has been set, clk_en[3] stays 0 after bit 3 is cleared, until trc_sw_rst is sampled high at a rising edge while bit 3 is 0. From then on the trace clock runs, including after trc_sw_rst is released.
- R8: clk_en changes only while clk is low, and gclk[i] equals clk AND clk_en[i].
- R9: A write accepted at a rising edge is visible on rd_data directly after that edge. Its effect on clk_en appears in the low phase that follows the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the register and all gated clocks |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 16 | Key in [15:8], register data in [7:0] |
| trc_sw_rst | input | 1 | Trace unit software reset, active high |
| rd_data | output | 8 | Current register value |
| clk_en | output | 4 | Latched per-module clock enables |
| gclk | output | 4 | Gated clocks: break, floating-point, debug interface, trace |

## Verification
A wrong stored bit shows on rd_data right after the write edge, and on the matching gclk within the next clock phase. A lost sticky bit on the floating-point stop only shows when a keyed write of 0 follows the set, so the bench writes exactly that pattern and then looks at both rd_data and gclk[1]. The trace interlock is tested by clearing bit 3 with and without a software reset pulse in between, and the enable is watched over several cycles in each case. That way a permit flag that sets too early, or never sets, shows up at clk_en[3].

// File: rtl/modstop_pkg.sv
// Shared constants for the module-stop clock controller.
// Assumes four gated modules, in the bit order listed below.
package modstop_pkg;
    localparam int NUM_MOD  = 4;
    localparam int DATA_W   = 8;
    localparam int KEY_W    = 8;
    localparam int BUS_W    = KEY_W + DATA_W;
    localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
    localparam int IDX_BRK  = 0;
    localparam int IDX_FPU  = 1;
    localparam int IDX_DBG  = 2;
    localparam int IDX_TRC  = 3;
    localparam logic [NUM_MOD-1:0] STOP_RST = 4'b0001;
endpackage

// File: rtl/modstop_reg.sv
// Keyed stop register. A write is accepted only when the key sits in the
// upper byte. The sticky bit can only be set; a power-on reset clears it.
// Assumes wr_en and wr_data are stable around the rising edge.
module modstop_reg #(
    parameter int NUM_MOD = 4,
    parameter int DATA_W  = 8,
    parameter int KEY_W   = 8,
    parameter int STICKY  = 1,
    parameter logic [KEY_W-1:0]   KEY     = 8'h5A,
    parameter logic [NUM_MOD-1:0] RST_VAL = 4'b0001
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [KEY_W+DATA_W-1:0]   wr_data,
    output logic [NUM_MOD-1:0]        stop
);
    localparam int BUS_W = KEY_W + DATA_W;

    logic               key_ok;
    logic [NUM_MOD-1:0] wdat;

    // Decode an accepted write.
    always_comb begin
        key_ok = wr_en && (wr_data[BUS_W-1:DATA_W] == KEY);
        wdat   = wr_data[NUM_MOD-1:0];
    end

    // Store the stop bits; the sticky bit ORs in new data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop <= RST_VAL;
        end else if (key_ok) begin
            for (int i = 0; i < NUM_MOD; i++) begin
                if (i == STICKY) stop[i] <= stop[i] | wdat[i];
                else             stop[i] <= wdat[i];
            end
        end
    end

    // R5
    fpu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop[STICKY] |=> stop[STICKY]);
    // R3
    nokey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data[BUS_W-1:DATA_W] != KEY) |=> $stable(stop));
    // R4
    keyed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BUS_W-1:DATA_W] == KEY)
        |=> (stop[0] == $past(wr_data[0])) && (stop[NUM_MOD-1] == $past(wr_data[NUM_MOD-1])));
endmodule

// File: rtl/trace_interlock.sv
// Restart permit for the trace unit. A stop clears the permit. After the
// stop bit is cleared, the permit comes back only when the trace software
// reset is seen high. Assumes the stop bit is held for at least one cycle.
module trace_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_trc,
    input  logic sw_rst,
    output logic restart_ok
);
    // Clear on stop, set on software reset while running is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)        restart_ok <= 1'b1;
        else if (stop_trc) restart_ok <= 1'b0;
        else if (sw_rst)   restart_ok <= 1'b1;
    end

    // R7
    stop_clears_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_trc |=> !restart_ok);
    // R7
    ok_needs_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_ok && !sw_rst) |=> !restart_ok);
endmodule

// File: rtl/clk_gate_cell.sv
// Glitch-free clock gate. The enable is captured by a latch that is open
// only while clk is low, then ANDed with clk. Assumes en settles in the low phase.
module clk_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic en_lat,
    output logic gclk
);
    // Hold the enable through the high phase.
    always_latch begin
        if (!clk) en_lat = en;
    end

    // Form the gated clock.
    always_comb gclk = clk & en_lat;

    // R8
    gate_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_lat == en);
endmodule

// File: rtl/modstop_ctrl.sv
// Top of the module-stop clock controller: keyed register, trace restart
// interlock and one clock gate per module. Bit i of the register stops module i.
module modstop_ctrl
    import modstop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              trc_sw_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_MOD-1:0] clk_en,
    output logic [NUM_MOD-1:0] gclk
);
    logic [NUM_MOD-1:0] stop;
    logic [NUM_MOD-1:0] en_req;
    logic               trc_ok;

    modstop_reg #(
        .NUM_MOD(NUM_MOD), .DATA_W(DATA_W), .KEY_W(KEY_W),
        .STICKY(IDX_FPU), .KEY(WR_KEY), .RST_VAL(STOP_RST)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .stop(stop)
    );

    trace_interlock u_trc (
        .clk(clk), .rst_n(rst_n), .stop_trc(stop[IDX_TRC]),
        .sw_rst(trc_sw_rst), .restart_ok(trc_ok)
    );

    // Read back the stop bits; reserved bits are zero.
    always_comb rd_data = {{(DATA_W-NUM_MOD){1'b0}}, stop};

    // Requested enable per module, with the trace interlock.
    always_comb begin
        for (int i = 0; i < NUM_MOD; i++) begin
            if (i == IDX_TRC) en_req[i] = !stop[i] && trc_ok;
            else              en_req[i] = !stop[i];
        end
    end

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_gate
        clk_gate_cell u_gate (
            .clk(clk), .rst_n(rst_n), .en(en_req[g]),
            .en_lat(clk_en[g]), .gclk(gclk[g])
        );
    end

    // R6
    stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop & clk_en) == '0);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NUM_MOD] == '0);
endmodule

// File: tb/tb_modstop_ctrl.sv
// Directed bench for modstop_ctrl: one task per scenario.
module tb_modstop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        trc_sw_rst = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  clk_en;
    logic [3:0]  gclk;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    modstop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trc_sw_rst(trc_sw_rst), .rd_data(rd_data), .clk_en(clk_en), .gclk(gclk)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Keyed or unkeyed write; returns at the negedge after the write edge.
    task automatic do_write(input logic [7:0] key, input logic [7:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {key, dat};
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Sample enables and gated clocks in the middle of a high phase.
    task automatic chk_gate(input string tag, input logic [3:0] exp_en);
        @(posedge clk); #2;
        chk({tag, " clk_en"}, {4'b0, clk_en}, {4'b0, exp_en});
        chk({tag, " gclk"},   {4'b0, gclk},   {4'b0, exp_en});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; trc_sw_rst = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset value", rd_data, 8'h01);
        chk_gate("R1 reset enables", 4'b1110);
        @(negedge clk); #1;
        chk("R8 gclk low in low phase", {4'b0, gclk}, 8'h00);
    endtask

    task automatic t_key();
        do_write(8'hA5, 8'h0D);
        chk("R3 wrong key ignored", rd_data, 8'h01);
        do_write(8'h00, 8'h0C);
        chk("R3 zero key ignored", rd_data, 8'h01);
        chk_gate("R3 enables unchanged", 4'b1110);
        do_write(8'h5A, 8'hF4);
        chk("R2/R4 keyed write, upper read zero", rd_data, 8'h04);
        chk_gate("R6 debug iface stopped", 4'b1011);
        do_write(8'h5A, 8'h00);
        chk("R4 clear all writable", rd_data, 8'h00);
        chk_gate("R6 all running", 4'b1111);
    endtask

    task automatic t_timing();
        do_write(8'h5A, 8'h01);
        // R9: already in the low phase after the write edge the enable is new
        #1;
        chk("R9 enable after write edge", {4'b0, clk_en}, 8'h0E);
        chk("R9 read after write edge", rd_data, 8'h01);
    endtask

    task automatic t_fpu();
        do_write(8'h5A, 8'h02);
        chk("R5 fpu stop set", rd_data, 8'h02);
        chk_gate("R6 fpu clock stopped", 4'b1101);
        do_write(8'h5A, 8'h00);
        chk("R5 fpu clear ignored", rd_data, 8'h02);
        chk_gate("R5 fpu stays stopped", 4'b1101);
        do_reset();
        chk("R5 reset clears fpu stop", rd_data, 8'h01);
    endtask

    task automatic t_trace();
        do_write(8'h5A, 8'h08);
        chk_gate("R6 trace stopped", 4'b0111);
        do_write(8'h5A, 8'h00);
        chk("R7 bit3 cleared", rd_data, 8'h00);
        repeat (3) @(posedge clk);
        chk_gate("R7 trace held off without sw reset", 4'b0111);
        @(negedge clk); trc_sw_rst = 1'b1;
        @(negedge clk); trc_sw_rst = 1'b0;
        chk_gate("R7 trace runs after sw reset", 4'b1111);
        repeat (3) @(posedge clk);
        chk_gate("R7 trace still runs after release", 4'b1111);
        // sw reset pulsed while stopped does not count
        do_write(8'h5A, 8'h08);
        @(negedge clk); trc_sw_rst = 1'b1;
        @(negedge clk); trc_sw_rst = 1'b0;
        do_write(8'h5A, 8'h00);
        repeat (2) @(posedge clk);
        chk_gate("R7 pulse during stop ignored", 4'b0111);
    endtask

    initial begin
        t_reset();
        t_key();
        t_timing();
        t_fpu();
        t_trace();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule